// File: doc/BRIEF.md
# UART Host Register Bridge

This block connects a four-register host I/O window to an 8-bit UART that offers separate data access and command/status access. Host bytes written for the UART are held in an outbound latch, and a write-request flag is set. Host read requests are recorded by a read-request flag. Neither request goes to the UART at the moment the host asks. Each is handed over later, with a one-clock strobe, once the UART says it is ready for that direction or once command access is selected. Inbound bytes are captured into a holding register, which the host then reads back.

The block produces two host-side outputs, both combinational. The first is a ready flag. It waits for configuration to finish, and it waits for any pending request whose direction has its interrupt enable cleared. The second is an interrupt line, gated by a master enable. The block also presents a status register that holds the modem-status inputs and two strap inputs. A loopback input substitutes the block's own 3-bit line-output latch for the modem bits in that register. Writing a control byte with one reserved bit set performs an internal reset of the bridge state.

Top module: `uart_host_bridge`

## Requirements
- R1: After `rst` the control register reads 0x10, `line_out` and `half_rate` are 0, `hst_irq` and both UART strobes are 0, register 0 reads 0, and the data direction is inbound.
- R2: A host write to register 0 latches the byte and sets a write request. The request stays pending while neither `uart_txrdy` nor command select is 1. In the cycle after a clock edge at which it is pending and one of them is 1, `uart_wr_stb` is 1 for one cycle, `uart_wdata` holds the byte and the request is cleared.
- R3: A host write to register 3 sets a read request only if the last register-0 access was a read (inbound). After a register-0 write the register-3 write is ignored.
- R4: A pending read request completes at the first clock edge at which `uart_rxrdy` or command select is 1. `uart_rdata` is captured at that edge, `uart_rd_stb` is 1 for the following cycle, and a register-0 read then returns the captured byte.
- R5: Register 1 write fields are: bit 0 command select, bit 1 transmit interrupt enable, bit 2 receive interrupt enable, bit 7 master enable. The read-back places transmit enable on bit 0, receive enable on bit 1, master enable on bit 7 and a constant 1 on bit 4, with all other bits 0.
- R6: A register-1 write with bit 5 set ignores its other bits. It clears both data registers, both requests, all enables, command select, `half_rate` and `line_out`.
- R7: A register-2 write drives `half_rate` from bit 4 and `line_out` from bits 2:0.
- R8: A register-2 read returns 1 on bits 7:5 and `jmp_cfg` on bits 4:3. Bits 2:0 are {0, ~`mdm_ri`, ~`mdm_dcd`}, or `line_out` when `loop_en` is 1.
- R9: `hst_ready` = `init_done` AND (no write pending OR transmit enable) AND (no read pending OR receive enable).
- R10: `hst_irq` = master enable AND ((transmit enable AND `uart_txrdy`) OR (receive enable AND no read pending)).
- R11: `uart_cd` follows command select (1 = command/status access, 0 = data access).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 2 | Host register select (0 data, 1 control, 2 line/status, 3 read request) |
| hst_wr | input | 1 | Host write strobe, one cycle per access |
| hst_rd | input | 1 | Host read strobe, one cycle per access |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data for the selected register (combinational) |
| hst_ready | output | 1 | Host ready flag |
| hst_irq | output | 1 | Host interrupt request |
| init_done | input | 1 | UART configuration finished |
| uart_txrdy | input | 1 | UART can accept a byte |
| uart_rxrdy | input | 1 | UART holds a received byte |
| uart_rdata | input | DATA_W | UART read data |
| uart_cd | output | 1 | UART access select, 1 = command/status |
| uart_wr_stb | output | 1 | One-cycle UART write strobe |
| uart_rd_stb | output | 1 | One-cycle UART read strobe |
| uart_wdata | output | DATA_W | UART write data |
| mdm_dcd | input | 1 | Carrier-detect line level |
| mdm_ri | input | 1 | Ring-indicator line level |
| jmp_cfg | input | 2 | Strap inputs |
| loop_en | input | 1 | Loopback select for status bits |
| half_rate | output | 1 | Half-rate bit-clock control |
| line_out | output | 3 | Line-output latch |

## Verification
The control register is swept over all 256 write values. The sweep shows that each enable lands on its read-back bit, and that any value with bit 5 set collapses to the reset read-back. All 256 line-register writes and all 32 combinations of straps, modem lines and loopback are applied, so the modem path and the loopback path are told apart on bits 2:0. The flag and interrupt equations are driven through all 128 combinations of the three enables, configuration done, transmit-ready and the two pending requests. Directed sequences separate the ready-gated and the command-forced transfers for each direction, and a register-3 write made after a register-0 write is shown to be dropped.

// File: rtl/uhb_pkg.sv
package uhb_pkg;

    localparam int BYTE_W   = 8;
    localparam int LINE_W   = 3;
    localparam int JMP_W    = 2;

    // control register bit positions (host software decodes these)
    localparam int CMD_BIT  = 0;
    localparam int TXE_BIT  = 1;
    localparam int RXE_BIT  = 2;
    localparam int HALF_BIT = 4;
    localparam int IRST_BIT = 5;
    localparam int MIE_BIT  = 7;
    localparam int ONE_BIT  = 4;
    localparam int TXE_RB   = 0;
    localparam int RXE_RB   = 1;
    localparam int JMP_LSB  = 3;

    typedef enum logic [1:0] {
        REG_DATA  = 2'd0,
        REG_CTRL  = 2'd1,
        REG_LINE  = 2'd2,
        REG_RDREQ = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic mie;
        logic rx_ie;
        logic tx_ie;
        logic cmd_sel;
    } ctrl_t;

    function automatic logic [BYTE_W-1:0] ctrl_readback(input logic mie,
                                                        input logic rx_ie,
                                                        input logic tx_ie);
        logic [BYTE_W-1:0] b;
        b           = '0;
        b[TXE_RB]   = tx_ie;
        b[RXE_RB]   = rx_ie;
        b[ONE_BIT]  = 1'b1;
        b[MIE_BIT]  = mie;
        return b;
    endfunction

    function automatic logic [BYTE_W-1:0] line_readback(input logic [JMP_W-1:0]  jmp,
                                                        input logic [LINE_W-1:0] low);
        logic [BYTE_W-1:0] b;
        b                           = '1;
        b[JMP_LSB +: JMP_W]         = jmp;
        b[LINE_W-1:0]               = low;
        return b;
    endfunction

endpackage

// File: rtl/uhb_regfile.sv
module uhb_regfile
    import uhb_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              half_q,
    output logic [LINE_W-1:0] line_q,
    output logic              dir_in_q,
    output logic [DATA_W-1:0] out_byte_q,
    output logic              irst,
    output logic              wr_req,
    output logic              rd_req
);

    logic wr_data, wr_ctrl, wr_line, wr_rdrq, rd_data;

    assign wr_data = wr && (sel == REG_DATA);
    assign wr_ctrl = wr && (sel == REG_CTRL);
    assign wr_line = wr && (sel == REG_LINE);
    assign wr_rdrq = wr && (sel == REG_RDREQ);
    assign rd_data = rd && (sel == REG_DATA);

    assign irst    = wr_ctrl && wdata[IRST_BIT];
    assign wr_req  = wr_data;
    assign rd_req  = wr_rdrq && dir_in_q;

    // direction survives the internal reset; only the chip reset sets it
    always_ff @(posedge clk) begin
        if (rst)          dir_in_q <= 1'b1;
        else if (wr_data) dir_in_q <= 1'b0;
        else if (rd_data) dir_in_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || irst) begin
            ctrl_q     <= '0;
            half_q     <= 1'b0;
            line_q     <= '0;
            out_byte_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.cmd_sel <= wdata[CMD_BIT];
                ctrl_q.tx_ie   <= wdata[TXE_BIT];
                ctrl_q.rx_ie   <= wdata[RXE_BIT];
                ctrl_q.mie     <= wdata[MIE_BIT];
            end
            if (wr_line) begin
                half_q <= wdata[HALF_BIT];
                line_q <= wdata[LINE_W-1:0];
            end
            if (wr_data) out_byte_q <= wdata;
        end
    end

endmodule

// File: rtl/uhb_req_chan.sv
module uhb_req_chan #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         set,
    input  logic         ready,
    input  logic         bypass,
    input  logic [W-1:0] d,
    output logic         pend_q,
    output logic         stb_q,
    output logic [W-1:0] q
);

    logic go;
    assign go = pend_q && (ready || bypass);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend_q <= 1'b0;
            stb_q  <= 1'b0;
            q      <= '0;
        end else begin
            stb_q <= go;
            if (go) q <= d;
            if (set)     pend_q <= 1'b1;
            else if (go) pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/uhb_status.sv
module uhb_status
    import uhb_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic [1:0]        sel,
    input  logic              mie,
    input  logic              tx_ie,
    input  logic              rx_ie,
    input  logic              wr_pend,
    input  logic              rd_pend,
    input  logic              init_done,
    input  logic              txrdy,
    input  logic [DATA_W-1:0] in_byte,
    input  logic [LINE_W-1:0] line_q,
    input  logic [JMP_W-1:0]  jmp,
    input  logic              dcd,
    input  logic              ri,
    input  logic              loop_en,
    output logic              ready,
    output logic              irq,
    output logic [DATA_W-1:0] rdata
);

    logic [LINE_W-1:0] low_bits;

    assign ready = init_done && (!wr_pend || tx_ie) && (!rd_pend || rx_ie);
    assign irq   = mie && ((tx_ie && txrdy) || (rx_ie && !rd_pend));

    always_comb begin
        low_bits = '0;
        if (loop_en) begin
            low_bits = line_q;
        end else begin
            low_bits[0] = ~dcd;
            low_bits[1] = ~ri;
        end
    end

    always_comb begin
        unique case (sel)
            REG_DATA: rdata = in_byte;
            REG_CTRL: rdata = DATA_W'(ctrl_readback(mie, rx_ie, tx_ie));
            REG_LINE: rdata = DATA_W'(line_readback(jmp, low_bits));
            default:  rdata = '0;
        endcase
    end

endmodule

// File: rtl/uart_host_bridge.sv
module uart_host_bridge
    import uhb_pkg::*;
#(
    parameter int DATA_W = BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           hst_sel,
    input  logic                 hst_wr,
    input  logic                 hst_rd,
    input  logic [DATA_W-1:0]    hst_wdata,
    output logic [DATA_W-1:0]    hst_rdata,
    output logic                 hst_ready,
    output logic                 hst_irq,
    input  logic                 init_done,
    input  logic                 uart_txrdy,
    input  logic                 uart_rxrdy,
    input  logic [DATA_W-1:0]    uart_rdata,
    output logic                 uart_cd,
    output logic                 uart_wr_stb,
    output logic                 uart_rd_stb,
    output logic [DATA_W-1:0]    uart_wdata,
    input  logic                 mdm_dcd,
    input  logic                 mdm_ri,
    input  logic [JMP_W-1:0]     jmp_cfg,
    input  logic                 loop_en,
    output logic                 half_rate,
    output logic [LINE_W-1:0]    line_out
);

    ctrl_t             ctrl_q;
    logic              dir_in_q;
    logic [DATA_W-1:0] out_byte_q;
    logic [DATA_W-1:0] in_byte_q;
    logic              irst, wr_req, rd_req;
    logic              wr_pend_q, rd_pend_q;

    uhb_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .sel        (hst_sel),
        .wr         (hst_wr),
        .rd         (hst_rd),
        .wdata      (hst_wdata),
        .ctrl_q     (ctrl_q),
        .half_q     (half_rate),
        .line_q     (line_out),
        .dir_in_q   (dir_in_q),
        .out_byte_q (out_byte_q),
        .irst       (irst),
        .wr_req     (wr_req),
        .rd_req     (rd_req)
    );

    // outbound: host byte -> UART
    uhb_req_chan #(.W(DATA_W)) u_wr_chan (
        .clk    (clk),
        .rst    (rst),
        .clr    (irst),
        .set    (wr_req),
        .ready  (uart_txrdy),
        .bypass (ctrl_q.cmd_sel),
        .d      (out_byte_q),
        .pend_q (wr_pend_q),
        .stb_q  (uart_wr_stb),
        .q      (uart_wdata)
    );

    // inbound: UART byte -> host
    uhb_req_chan #(.W(DATA_W)) u_rd_chan (
        .clk    (clk),
        .rst    (rst),
        .clr    (irst),
        .set    (rd_req),
        .ready  (uart_rxrdy),
        .bypass (ctrl_q.cmd_sel),
        .d      (uart_rdata),
        .pend_q (rd_pend_q),
        .stb_q  (uart_rd_stb),
        .q      (in_byte_q)
    );

    uhb_status #(.DATA_W(DATA_W)) u_status (
        .sel       (hst_sel),
        .mie       (ctrl_q.mie),
        .tx_ie     (ctrl_q.tx_ie),
        .rx_ie     (ctrl_q.rx_ie),
        .wr_pend   (wr_pend_q),
        .rd_pend   (rd_pend_q),
        .init_done (init_done),
        .txrdy     (uart_txrdy),
        .in_byte   (in_byte_q),
        .line_q    (line_out),
        .jmp       (jmp_cfg),
        .dcd       (mdm_dcd),
        .ri        (mdm_ri),
        .loop_en   (loop_en),
        .ready     (hst_ready),
        .irq       (hst_irq)
        ,.rdata    (hst_rdata)
    );

    assign uart_cd = ctrl_q.cmd_sel;

endmodule

// File: rtl/uhb_checker.sv
module uhb_checker
    import uhb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [1:0]        hst_sel,
    input logic              hst_wr,
    input logic              irst_bit,
    input logic              half_bit,
    input logic [LINE_W-1:0] line_bits,
    input logic              hst_ready,
    input logic              hst_irq,
    input logic              init_done,
    input logic              uart_txrdy,
    input logic              uart_rxrdy,
    input logic              uart_cd,
    input logic              uart_wr_stb,
    input logic              uart_rd_stb,
    input logic              half_rate,
    input logic [LINE_W-1:0] line_out,
    input logic              mie_q
);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (line_out == '0) && !half_rate && !hst_irq && !uart_wr_stb && !uart_rd_stb);

    p_wr_cause_r2: assert property (@(posedge clk) disable iff (rst)
        uart_wr_stb |-> $past(uart_txrdy || uart_cd));

    p_rd_cause_r4: assert property (@(posedge clk) disable iff (rst)
        uart_rd_stb |-> $past(uart_rxrdy || uart_cd));

    p_irst_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $past(hst_wr && (hst_sel == REG_CTRL) && irst_bit)
        |-> (line_out == '0) && !half_rate && !hst_irq && !uart_wr_stb && !uart_rd_stb);

    p_line_write_r7: assert property (@(posedge clk) disable iff (rst)
        $past(hst_wr && (hst_sel == REG_LINE) && !rst)
        |-> (line_out == $past(line_bits)) && (half_rate == $past(half_bit)));

    p_ready_init_r9: assert property (@(posedge clk) disable iff (rst)
        hst_ready |-> init_done);

    p_irq_master_r10: assert property (@(posedge clk) disable iff (rst)
        hst_irq |-> mie_q);

endmodule

bind uart_host_bridge uhb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .hst_sel    (hst_sel),
    .hst_wr     (hst_wr),
    .irst_bit   (hst_wdata[uhb_pkg::IRST_BIT]),
    .half_bit   (hst_wdata[uhb_pkg::HALF_BIT]),
    .line_bits  (hst_wdata[uhb_pkg::LINE_W-1:0]),
    .hst_ready  (hst_ready),
    .hst_irq    (hst_irq),
    .init_done  (init_done),
    .uart_txrdy (uart_txrdy),
    .uart_rxrdy (uart_rxrdy),
    .uart_cd    (uart_cd),
    .uart_wr_stb(uart_wr_stb),
    .uart_rd_stb(uart_rd_stb),
    .half_rate  (half_rate),
    .line_out   (line_out),
    .mie_q      (ctrl_q.mie)
);

// File: tb/uart_host_bridge_test.sv
`timescale 1ns/1ps
module uart_host_bridge_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] hst_sel = 2'd0;
    logic       hst_wr = 1'b0, hst_rd = 1'b0;
    logic [7:0] hst_wdata = 8'h00;
    logic [7:0] hst_rdata;
    logic       hst_ready, hst_irq;
    logic       init_done = 1'b1;
    logic       uart_txrdy = 1'b0, uart_rxrdy = 1'b0;
    logic [7:0] uart_rdata = 8'h00;
    logic       uart_cd, uart_wr_stb, uart_rd_stb;
    logic [7:0] uart_wdata;
    logic       mdm_dcd = 1'b0, mdm_ri = 1'b0;
    logic [1:0] jmp_cfg = 2'b00;
    logic       loop_en = 1'b0;
    logic       half_rate;
    logic [2:0] line_out;

    int n_chk = 0;
    int n_fail = 0;
    int rd_stb_cnt = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_host_bridge uut (
        .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_wr(hst_wr), .hst_rd(hst_rd),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_ready(hst_ready), .hst_irq(hst_irq),
        .init_done(init_done), .uart_txrdy(uart_txrdy), .uart_rxrdy(uart_rxrdy),
        .uart_rdata(uart_rdata), .uart_cd(uart_cd), .uart_wr_stb(uart_wr_stb),
        .uart_rd_stb(uart_rd_stb), .uart_wdata(uart_wdata), .mdm_dcd(mdm_dcd), .mdm_ri(mdm_ri),
        .jmp_cfg(jmp_cfg), .loop_en(loop_en), .half_rate(half_rate), .line_out(line_out)
    );

    always @(negedge clk) if (uart_rd_stb) rd_stb_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        hst_sel = s; hst_wdata = d; hst_wr = 1'b1;
        @(negedge clk);
        hst_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        hst_sel = s; hst_rd = 1'b1;
        #1 d = hst_rdata;
        @(negedge clk);
        hst_rd = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int cnt0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        hread(2'd1, r);  chk("R1 ctrl readback", r, 8'h10);
        hread(2'd0, r);  chk("R1 data reg", r, 8'h00);
        chk("R1 line_out", line_out, 0);
        chk("R1 half_rate", half_rate, 0);
        chk("R1 irq", hst_irq, 0);
        chk("R1 strobes", {uart_wr_stb, uart_rd_stb}, 0);
        chk("R1 ready", hst_ready, 1);

        // R5/R6/R11: every control value
        for (int v = 0; v < 256; v++) begin
            logic [7:0] e;
            logic [7:0] b;
            b = 8'(v);
            e = b[5] ? 8'h10 : {b[7], 2'b00, 1'b1, 2'b00, b[2], b[1]};
            hwrite(2'd1, b);
            hread(2'd1, r);
            chk(b[5] ? "R6 ctrl cleared" : "R5 ctrl readback", r, e);
            chk("R11 cmd select", uart_cd, b[0] & ~b[5]);
        end

        // R7: every line register write
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            hwrite(2'd2, b);
            chk("R7 line_out", line_out, b[2:0]);
            chk("R7 half_rate", half_rate, b[4]);
        end

        // R8: straps x modem x loopback
        for (int c = 0; c < 32; c++) begin
            logic [2:0] k;
            logic [2:0] low;
            k = 3'(c * 3);
            hwrite(2'd2, {5'b0, k});
            jmp_cfg = c[1:0]; mdm_dcd = c[2]; mdm_ri = c[3]; loop_en = c[4];
            low = loop_en ? k : {1'b0, ~mdm_ri, ~mdm_dcd};
            hread(2'd2, r);
            chk("R8 line readback", r, {3'b111, jmp_cfg, low});
        end
        loop_en = 1'b0;

        // R2: deferred transfer waits for transmit-ready
        hwrite(2'd1, 8'h20);
        hwrite(2'd0, 8'hA5);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2 held while not ready", uart_wr_stb, 0);
        end
        uart_txrdy = 1'b1;
        @(negedge clk);
        chk("R2 strobe", uart_wr_stb, 1);
        chk("R2 wdata", uart_wdata, 8'hA5);
        chk("R2 data access", uart_cd, 0);
        uart_txrdy = 1'b0;
        @(negedge clk);
        chk("R2 one cycle", uart_wr_stb, 0);

        // R2/R11: command access forces the write
        hwrite(2'd1, 8'h01);
        hwrite(2'd0, 8'h5A);
        @(negedge clk);
        chk("R2 cmd strobe", uart_wr_stb, 1);
        chk("R2 cmd wdata", uart_wdata, 8'h5A);
        chk("R11 cmd access", uart_cd, 1);

        // R4: read capture gated by receive-ready
        hwrite(2'd1, 8'h20);
        hread(2'd0, r);
        uart_rdata = 8'h9E;
        hwrite(2'd3, 8'h00);
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R4 held while not ready", uart_rd_stb, 0);
        end
        uart_rxrdy = 1'b1;
        @(negedge clk);
        chk("R4 strobe", uart_rd_stb, 1);
        uart_rxrdy = 1'b0;
        uart_rdata = 8'h00;
        @(negedge clk);
        chk("R4 one cycle", uart_rd_stb, 0);
        hread(2'd0, r);
        chk("R4 captured byte", r, 8'h9E);

        // R4: command access forces the read
        hwrite(2'd1, 8'h01);
        uart_rdata = 8'h47;
        hwrite(2'd3, 8'h00);
        @(negedge clk);
        chk("R4 cmd strobe", {uart_rd_stb, uart_cd}, 2'b11);
        uart_rdata = 8'h00;
        hread(2'd0, r);
        chk("R4 cmd captured", r, 8'h47);

        // R3: register 3 ignored after an outbound access
        hwrite(2'd1, 8'h20);
        uart_txrdy = 1'b1;
        hwrite(2'd0, 8'h11);
        @(negedge clk);
        uart_txrdy = 1'b0;
        uart_rxrdy = 1'b1;
        cnt0 = rd_stb_cnt;
        hwrite(2'd3, 8'h00);
        repeat (3) @(negedge clk);
        chk("R3 ignored when outbound", rd_stb_cnt - cnt0, 0);
        chk("R3 ready unaffected", hst_ready, 1);
        hread(2'd0, r);
        cnt0 = rd_stb_cnt;
        hwrite(2'd3, 8'h00);
        repeat (3) @(negedge clk);
        chk("R3 accepted when inbound", rd_stb_cnt - cnt0, 1);
        uart_rxrdy = 1'b0;

        // R6: internal reset clears live state
        hwrite(2'd1, 8'h86);
        hwrite(2'd2, 8'h17);
        hread(2'd0, r);
        uart_rdata = 8'hC3;
        uart_rxrdy = 1'b1;
        hwrite(2'd3, 8'h00);
        @(negedge clk);
        uart_rxrdy = 1'b0;
        hread(2'd0, r);
        chk("R6 setup capture", r, 8'hC3);
        hwrite(2'd0, 8'h77);
        hwrite(2'd1, 8'hA7);
        hread(2'd1, r);  chk("R6 ctrl", r, 8'h10);
        hread(2'd0, r);  chk("R6 data cleared", r, 8'h00);
        chk("R6 line/half", {half_rate, line_out}, 0);
        chk("R6 irq", hst_irq, 0);
        chk("R6 no pending", hst_ready, 1);
        uart_txrdy = 1'b1;
        cnt0 = 0;
        repeat (3) begin
            @(negedge clk);
            if (uart_wr_stb) cnt0++;
        end
        chk("R6 write request dropped", cnt0, 0);
        uart_txrdy = 1'b0;

        // R9/R10: full sweep of flag and interrupt terms
        for (int c = 0; c < 128; c++) begin
            bit tx, rx, mie, ini, txr, wp, rp;
            bit e_rdy, e_irq;
            tx = c[0]; rx = c[1]; mie = c[2]; ini = c[3];
            txr = c[4]; wp = c[5]; rp = c[6];
            init_done = 1'b1; uart_txrdy = 1'b0; uart_rxrdy = 1'b0;
            hwrite(2'd1, 8'h20);
            hwrite(2'd1, {mie, 4'b0, rx, tx, 1'b0});
            if (wp) hwrite(2'd0, 8'h3C);
            if (rp) begin
                hread(2'd0, r);
                hwrite(2'd3, 8'h00);
            end
            @(negedge clk);
            init_done = ini; uart_txrdy = txr;
            #1;
            e_rdy = ini & (~wp | tx) & (~rp | rx);
            e_irq = mie & ((tx & txr) | (rx & ~rp));
            chk("R9 ready flag", hst_ready, e_rdy);
            chk("R10 irq", hst_irq, e_irq);
            uart_txrdy = 1'b0;
            init_done = 1'b1;
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule